// File: doc/BRIEF.md
# Register-Loaded JTAG Burst Shifter

This block drives a JTAG chain from a host register port. The host first writes a control word that holds the TCK divider, a 5-bit target-select code and the burst length. It then writes one 32-bit data word. The upper half of the data word carries the TMS pattern and the lower half carries the TDI pattern. For each TCK cycle of the burst, the block presents one TMS bit and one TDI bit. It samples TDO at every falling edge of TCK and collects the samples into a capture register. The host reads the capture register back through the data address.

A `busy` output is high for the whole burst. While `busy` is high, new data writes are dropped. Control writes are accepted at any time, but a burst keeps the divider and length that were in force when it began. The select code is checked against a fixed set of legal codes. The registered `dev_sel` output carries the code if it is legal and zero if it is not. Routing that code to real chains is left to the logic that surrounds the block.

Top module: `jtag_burst_master`

## Requirements
- R1: After a synchronous reset, `busy`, `tck`, `tms`, `tdi` and `dev_sel` are 0, and `rd_data` is 0 for both addresses.
- R2: A write with `wr_addr`=0 while `busy` is 0 starts a burst, and `busy` is 1 from the next cycle. `busy` falls in the same cycle as the last TCK falling edge. `tck` is 0 whenever `busy` is 0.
- R3: Let n be control bits [5:0], as held when the burst started. Each TCK high phase and each TCK low phase lasts n+1 clock cycles. The first low phase starts in the cycle after the start write.
- R4: The first TMS and TDI values are data bits 31 and 15. They are driven from the start cycle. Each following bit (31-k and 15-k) is driven at the k-th falling edge. After the final edge, `tms` and `tdi` keep their last values. Both are stable while `tck` is high.
- R5: A burst runs exactly N = control[14:11] + 1 TCK cycles, so field value 0 gives 1 cycle and field value 15 gives 16 cycles. Only the top N bits of each data half are used.
- R6: A read with `rd_addr`=0 returns the capture register. The register is cleared at burst start and shifts TDO in at each falling edge, so the first sample ends up at bit N-1. Bits 31:16, and any bits above N-1, read as 0.
- R7: A data write while `busy` is 1 has no effect, including a write in the cycle of the final falling edge.
- R8: A write with `wr_addr`=1 stores bits [14:0] at any time. A read with `rd_addr`=1 returns those bits, with bits 31:15 as 0. A control change made during a burst does not alter that burst.
- R9: `dev_sel` equals control bits [10:6] when that code is one of 0x01, 0x03, 0x09, 0x0A, 0x0B, 0x0C, 0x11, 0x12, 0x13 or 0x14. For any other code it is 0. It updates one cycle after the control write.
- R10: `rd_data` is registered. It shows the register selected by `rd_addr`, with that register's value from the preceding cycle, one cycle after `rd_addr` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, twice the nominal TCK reference |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write target: 0 data word, 1 control word |
| wr_data | input | 32 | Write value |
| rd_addr | input | 1 | Read source: 0 capture, 1 control |
| rd_data | output | 32 | Registered read value |
| busy | output | 1 | Burst in progress |
| tck | output | 1 | JTAG test clock |
| tms | output | 1 | JTAG mode select |
| tdi | output | 1 | JTAG data to the target |
| tdo | input | 1 | JTAG data from the target |
| dev_sel | output | 5 | Legal target-select code, or 0 |

## Verification
The critical overlap is a data write that arrives in the same cycle as the final TCK falling edge. In that cycle `busy` is still high, so the write must be dropped, and the next write, one cycle later, must start a fresh burst. The bench provokes this by holding a stream of data writes, with changing words, across several short bursts. It also issues a control write while a burst is running, which must not bend that burst's phase length or cycle count. A behavioural model built from queues of pending bits is compared with every output on every clock, so a restart or a lost write shows up at once as a pin mismatch.

// File: rtl/jtag_burst_pkg.sv
package jtag_burst_pkg;

  // register addresses on the one-bit host port
  localparam logic REG_DATA = 1'b0;
  localparam logic REG_CTRL = 1'b1;

  // width of the target-select code the legal list is written for
  localparam int JB_SEL_W = 5;

  function automatic logic jb_code_ok(input logic [JB_SEL_W-1:0] code);
    logic ok;
    case (code)
      5'h01, 5'h03, 5'h09, 5'h0A, 5'h0B,
      5'h0C, 5'h11, 5'h12, 5'h13, 5'h14: ok = 1'b1;
      default:                           ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/jb_tck_timer.sv
module jb_tck_timer #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tck,
  output logic             fall_evt
);

  logic [DIV_W-1:0] ph_q;
  logic             tck_q;
  logic             hit;

  assign hit      = run && (ph_q == div);
  assign fall_evt = hit && tck_q;
  assign tck      = tck_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      ph_q  <= '0;
      tck_q <= 1'b0;
    end else if (hit) begin
      ph_q  <= '0;
      tck_q <= ~tck_q;
    end else begin
      ph_q  <= ph_q + 1'b1;
    end
  end

endmodule

// File: rtl/jb_shift_core.sv
module jb_shift_core #(
  parameter int HALF_W = 16,
  parameter int CNT_W  = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [2*HALF_W-1:0] word,
  input  logic [CNT_W-1:0]    cnt_m1,
  input  logic                fall_evt,
  input  logic                tdo,
  output logic                busy,
  output logic                tms,
  output logic                tdi,
  output logic [HALF_W-1:0]   capture
);

  localparam logic [CNT_W:0] LAST = (CNT_W+1)'(1);

  logic [HALF_W-1:0] tms_sh, tdi_sh, cap_q;
  logic [CNT_W:0]    left_q;
  logic              busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tms_sh <= '0;
      tdi_sh <= '0;
      cap_q  <= '0;
      left_q <= '0;
      busy_q <= 1'b0;
    end else if (start) begin
      tms_sh <= word[2*HALF_W-1:HALF_W];
      tdi_sh <= word[HALF_W-1:0];
      cap_q  <= '0;
      left_q <= {1'b0, cnt_m1} + LAST;
      busy_q <= 1'b1;
    end else if (fall_evt) begin
      cap_q  <= {cap_q[HALF_W-2:0], tdo};
      left_q <= left_q - LAST;
      if (left_q == LAST) begin
        busy_q <= 1'b0;
      end else begin
        tms_sh <= {tms_sh[HALF_W-2:0], 1'b0};
        tdi_sh <= {tdi_sh[HALF_W-2:0], 1'b0};
      end
    end
  end

  assign busy    = busy_q;
  assign tms     = tms_sh[HALF_W-1];
  assign tdi     = tdi_sh[HALF_W-1];
  assign capture = cap_q;

endmodule

// File: rtl/jb_sel_decode.sv
module jb_sel_decode
  import jtag_burst_pkg::*;
#(
  parameter int SEL_W = 5
) (
  input  logic [SEL_W-1:0] code_in,
  output logic [SEL_W-1:0] code_out
);

  logic legal;

  generate
    if (SEL_W == JB_SEL_W) begin : g_listed
      assign legal = jb_code_ok(code_in);
    end else begin : g_open
      assign legal = 1'b1;
    end
  endgenerate

  assign code_out = legal ? code_in : '0;

endmodule

// File: rtl/jtag_burst_master.sv
module jtag_burst_master
  import jtag_burst_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int DIV_W  = 6,
  parameter int SEL_W  = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                wr_addr,
  input  logic [2*HALF_W-1:0] wr_data,
  input  logic                rd_addr,
  output logic [2*HALF_W-1:0] rd_data,
  output logic                busy,
  output logic                tck,
  output logic                tms,
  output logic                tdi,
  input  logic                tdo,
  output logic [SEL_W-1:0]    dev_sel
);

  localparam int WORD_W  = 2 * HALF_W;
  localparam int CNT_W   = $clog2(HALF_W);
  localparam int SEL_LSB = DIV_W;
  localparam int CNT_LSB = DIV_W + SEL_W;
  localparam int CTRL_W  = CNT_LSB + CNT_W;

  logic [CTRL_W-1:0] ctrl_q;
  logic [DIV_W-1:0]  div_q;
  logic [SEL_W-1:0]  dev_q, dev_next;
  logic [WORD_W-1:0] rd_q;
  logic [HALF_W-1:0] capture;
  logic              start, fall_evt, busy_i;

  assign start = wr_en && (wr_addr == REG_DATA) && !busy_i;

  jb_sel_decode #(.SEL_W(SEL_W)) u_dec (
    .code_in  (wr_data[SEL_LSB +: SEL_W]),
    .code_out (dev_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      dev_q  <= '0;
      div_q  <= '0;
      rd_q   <= '0;
    end else begin
      if (wr_en && (wr_addr == REG_CTRL)) begin
        ctrl_q <= wr_data[CTRL_W-1:0];
        dev_q  <= dev_next;
      end
      if (start) begin
        div_q <= ctrl_q[DIV_W-1:0];
      end
      if (rd_addr == REG_CTRL) begin
        rd_q <= {{(WORD_W-CTRL_W){1'b0}}, ctrl_q};
      end else begin
        rd_q <= {{(WORD_W-HALF_W){1'b0}}, capture};
      end
    end
  end

  jb_tck_timer #(.DIV_W(DIV_W)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .run      (busy_i),
    .div      (div_q),
    .tck      (tck),
    .fall_evt (fall_evt)
  );

  jb_shift_core #(.HALF_W(HALF_W), .CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .word     (wr_data),
    .cnt_m1   (ctrl_q[CNT_LSB +: CNT_W]),
    .fall_evt (fall_evt),
    .tdo      (tdo),
    .busy     (busy_i),
    .tms      (tms),
    .tdi      (tdi),
    .capture  (capture)
  );

  assign busy    = busy_i;
  assign dev_sel = dev_q;
  assign rd_data = rd_q;

endmodule

// File: rtl/jtag_burst_master_chk.sv
module jtag_burst_master_chk
  import jtag_burst_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int DIV_W  = 6,
  parameter int SEL_W  = 5
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       wr_en,
  input logic                       wr_addr,
  input logic                       busy,
  input logic                       tck,
  input logic                       tms,
  input logic                       tdi,
  input logic [SEL_W-1:0]           dev_sel,
  input logic [SEL_W-1:0]           sel_field,
  input logic [$clog2(HALF_W)-1:0]  cnt_field,
  input logic [DIV_W-1:0]           div_q
);

  localparam int CNT_W = $clog2(HALF_W);

  logic             tck_d, busy_d;
  logic [DIV_W:0]   hi_len;
  logic [CNT_W-1:0] n_snap;
  logic [CNT_W:0]   falls;

  always_ff @(posedge clk) begin
    if (rst) begin
      tck_d  <= 1'b0;
      busy_d <= 1'b0;
      hi_len <= '0;
      n_snap <= '0;
      falls  <= '0;
    end else begin
      tck_d  <= tck;
      busy_d <= busy;
      if (tck != tck_d)    hi_len <= '0;
      else if (hi_len != '1) hi_len <= hi_len + 1'b1;
      if (wr_en && (wr_addr == REG_DATA) && !busy) n_snap <= cnt_field;
      if (busy && !busy_d)       falls <= '0;
      else if (tck_d && !tck)    falls <= falls + 1'b1;
    end
  end

  // R2: clock stays low outside a burst
  p_idle_low_r2: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !tck);

  // R3: high phase length matches the divider held for the burst
  p_phase_len_r3: assert property (@(posedge clk) disable iff (rst)
    (tck_d && !tck) |-> (hi_len == {1'b0, div_q}));

  // R4: pins do not move while the clock is high
  p_pins_stable_r4: assert property (@(posedge clk) disable iff (rst)
    tck |-> ($stable(tms) && $stable(tdi)));

  // R5: number of falling edges in a burst equals the programmed count
  p_cycle_count_r5: assert property (@(posedge clk) disable iff (rst)
    (busy_d && !busy) |-> (falls == {1'b0, n_snap}));

  // R7: a data write during a burst does not reload the divider
  p_no_restart_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_en && (wr_addr == REG_DATA)) |=> $stable(div_q));

  // R9: a nonzero select output is the stored legal code
  p_sel_match_r9: assert property (@(posedge clk) disable iff (rst)
    (dev_sel != '0) |-> (dev_sel == sel_field));

  p_sel_legal_r9: assert property (@(posedge clk) disable iff (rst)
    (dev_sel != '0) |-> jb_code_ok(dev_sel));

endmodule

bind jtag_burst_master jtag_burst_master_chk #(
  .HALF_W (HALF_W),
  .DIV_W  (DIV_W),
  .SEL_W  (SEL_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .busy      (busy),
  .tck       (tck),
  .tms       (tms),
  .tdi       (tdi),
  .dev_sel   (dev_sel),
  .sel_field (ctrl_q[DIV_W +: SEL_W]),
  .cnt_field (ctrl_q[DIV_W + SEL_W +: $clog2(HALF_W)]),
  .div_q     (div_q)
);

// File: tb/sim_jtag_burst_master.sv
`timescale 1ns/1ps
module sim_jtag_burst_master;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        wr_addr = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_addr = 1'b0;
  logic [31:0] rd_data;
  logic        busy, tck, tms, tdi, tdo;
  logic [4:0]  dev_sel;

  logic [7:0]  lfsr = 8'h5B;
  logic        tdo_hold = 1'b0;
  assign tdo = tdo_hold ? 1'b1 : lfsr[0];

  always #5 clk = ~clk;

  jtag_burst_master u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .tck(tck), .tms(tms),
    .tdi(tdi), .tdo(tdo), .dev_sel(dev_sel)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic bit legal(input logic [4:0] c);
    int codes[10] = '{1, 3, 9, 10, 11, 12, 17, 18, 19, 20};
    foreach (codes[i]) if (c == codes[i][4:0]) return 1'b1;
    return 1'b0;
  endfunction

  // ---------------- behavioural reference model ----------------
  logic [14:0] m_ctrl;
  logic [15:0] m_cap;
  logic [31:0] m_rd, nrd;
  logic [4:0]  m_dev;
  bit          m_busy, m_tck, m_tms, m_tdi, fall, start;
  int          m_ph, m_div, m_left, m_n;
  bit          q_tms[$], q_tdi[$];

  always @(posedge clk) begin
    if (rst) begin
      m_ctrl = '0; m_cap = '0; m_rd = '0; m_dev = '0;
      m_busy = 0; m_tck = 0; m_tms = 0; m_tdi = 0;
      m_ph = 0; m_div = 0; m_left = 0; m_n = 0;
      q_tms.delete(); q_tdi.delete();
    end else begin
      nrd   = rd_addr ? {17'd0, m_ctrl} : {16'd0, m_cap};
      start = wr_en && !wr_addr && !m_busy;
      fall  = 0;
      if (m_busy) begin
        if (m_ph == m_div) begin
          m_ph = 0; fall = m_tck; m_tck = !m_tck;
        end else m_ph++;
      end
      if (fall) begin
        m_cap = {m_cap[14:0], tdo};
        m_left--;
        if (m_left == 0) m_busy = 0;
        else begin m_tms = q_tms.pop_front(); m_tdi = q_tdi.pop_front(); end
      end
      if (start) begin
        m_n = int'(m_ctrl[14:11]) + 1;
        m_div = int'(m_ctrl[5:0]);
        q_tms.delete(); q_tdi.delete();
        for (int i = 0; i < m_n; i++) begin
          q_tms.push_back(wr_data[31-i]);
          q_tdi.push_back(wr_data[15-i]);
        end
        m_tms = q_tms.pop_front(); m_tdi = q_tdi.pop_front();
        m_cap = '0; m_left = m_n; m_busy = 1; m_ph = 0; m_tck = 0;
      end
      if (wr_en && wr_addr) begin
        m_ctrl = wr_data[14:0];
        m_dev  = legal(wr_data[10:6]) ? wr_data[10:6] : 5'd0;
      end
      m_rd = nrd;
    end
  end

  // ---------------- per-cycle comparison, stimulus for tdo, watchdog ----------------
  bit p_tck = 0, p_busy = 0;
  int falls_seen = 0;

  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
    if (!rst) begin
      check(busy == m_busy, "R2 busy", 32'(busy), 32'(m_busy));
      check(tck == m_tck, "R3 tck", 32'(tck), 32'(m_tck));
      check(tms == m_tms, "R4 tms", 32'(tms), 32'(m_tms));
      check(tdi == m_tdi, "R4 tdi", 32'(tdi), 32'(m_tdi));
      check(dev_sel == m_dev, "R9 dev_sel", 32'(dev_sel), 32'(m_dev));
      check(rd_data == m_rd, "R6 R8 R10 rd_data", rd_data, m_rd);
      if (!p_busy && busy) falls_seen = 0;
      if (p_tck && !tck) falls_seen++;
      if (p_busy && !busy)
        check(falls_seen == m_n, "R5 R7 falling edges per burst", 32'(falls_seen), 32'(m_n));
      p_tck = tck;
      p_busy = busy;
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (m_busy) @(negedge clk);
  endtask

  task automatic rd_expect(input logic a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    check(rd_data == exp, tag, rd_data, exp);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(busy == 1'b0, "R1 busy", 32'(busy), 0);
    check(tck == 1'b0, "R1 tck", 32'(tck), 0);
    check(tms == 1'b0 && tdi == 1'b0, "R1 tms/tdi", {30'd0, tms, tdi}, 0);
    check(dev_sel == 5'd0, "R1 dev_sel", 32'(dev_sel), 0);
    rd_expect(1'b1, 32'h0, "R1 ctrl readback");
    rd_expect(1'b0, 32'h0, "R1 capture readback");

    // R8/R9: control write with junk upper bits, 16 cycles, divider 0, code 0x03
    wr(1'b1, 32'hFFFF_78C0);
    check(dev_sel == 5'h03, "R9 legal code 0x03", 32'(dev_sel), 32'h03);
    rd_expect(1'b1, 32'h0000_78C0, "R8 ctrl readback");

    // R4/R5/R6: full 16-cycle burst with pattern tdo
    wr(1'b0, 32'hA5C3_3C5A);
    wait_idle();
    rd_expect(1'b0, {16'd0, m_cap}, "R6 capture after 16 cycles");

    // R3/R7/R8: 5 cycles, divider 2, code 0x14, tdo held high
    wr(1'b1, 32'h0000_2502);
    check(dev_sel == 5'h14, "R9 legal code 0x14", 32'(dev_sel), 32'h14);
    tdo_hold = 1'b1;
    wr(1'b0, 32'h1234_5678);
    repeat (4) @(negedge clk);
    wr(1'b0, 32'hFFFF_FFFF);          // R7: ignored, busy
    wr(1'b1, 32'h0000_0081);          // R8: 1 cycle, divider 1, code 0x02 for next burst
    check(dev_sel == 5'h00, "R9 illegal code 0x02", 32'(dev_sel), 0);
    wait_idle();
    check(m_n == 5, "R8 running burst kept its length", 32'(m_n), 5);
    rd_expect(1'b0, 32'h0000_001F, "R6 R7 capture right-aligned 5 ones");
    tdo_hold = 1'b0;

    // R5: single-cycle burst
    wr(1'b0, 32'h8000_0000);
    wait_idle();
    rd_expect(1'b1, 32'h0000_0081, "R8 ctrl readback after change");

    // R7: data writes held through back-to-back 2-cycle bursts, divider 0
    wr(1'b1, 32'h0000_0A80);
    check(dev_sel == 5'h0A, "R9 legal code 0x0A", 32'(dev_sel), 32'h0A);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 1'b0;
    for (int i = 0; i < 24; i++) begin
      wr_data = 32'hC0DE_0000 ^ (32'(i) * 32'h0101_9A37);
      @(negedge clk);
    end
    wr_en = 1'b0;
    wait_idle();

    // R9: illegal 0x1F, long divider, 8 cycles
    wr(1'b1, 32'h0000_3FC5);
    check(dev_sel == 5'h00, "R9 illegal code 0x1F", 32'(dev_sel), 0);
    wr(1'b0, 32'h6B2D_94E1);
    wait_idle();
    rd_expect(1'b0, {16'd0, m_cap}, "R6 capture after 8 cycles");

    // R9: another legal code, short burst
    wr(1'b1, 32'h0000_1440);
    check(dev_sel == 5'h11, "R9 legal code 0x11", 32'(dev_sel), 32'h11);
    wr(1'b0, 32'h7001_B002);
    wait_idle();
    repeat (3) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule